// File: doc/BRIEF.md
# Stepped Downward Summation Engine

The engine adds the integers from N down to 1 and presents the total. A caller puts N on `n_i` and pulses `start_i`. The value of N is captured in that same cycle. The engine then runs a fixed program of register operations on an index register I and an accumulator S. When the program has finished, `done_o` rises and `sum_o` holds N(N+1)/2. N is expected to be at least 1. The intended use is N > 1.

Control is not a single encoded state machine. It is a chain of four identical step controllers, one for each datapath operation:

| Index | Step | Operation |
|---|---|---|
| 0 | CLR_S | S←0 |
| 1 | LOAD_I | I←N |
| 2 | ADD | S←S+I |
| 3 | DEC | I←I−1 |

Every step controller has three states:

- ST_IDLE: the step is not active.
- ST_FIRE: the step pulses its evoke line for one cycle.
- ST_WAIT: the step waits for the datapath completion strobe.

The step controllers move between states as follows:

- ST_IDLE→ST_FIRE when the step is activated.
- ST_FIRE→ST_WAIT always, after one cycle.
- ST_WAIT→ST_IDLE when completion arrives. In that same cycle the step raises its activate-next line.

The datapath reports one Boolean, "I is zero", back to the chain. When the DEC step hands over, this flag chooses between two successors. If I is not zero, control returns to ADD. If I is zero, the run ends and done is set.

Top module: `sum_chain_seq`

## Requirements
- R1: After reset, `done_o` is 0, `sum_o` is 0 and no step is active.
- R2: A start pulse accepted while idle yields `sum_o` = N(N+1)/2 when `done_o` rises, for N from 1 up to the tested maximum.
- R3: The operations run in the order CLR_S, LOAD_I, then ADD and DEC repeated, with the I=0 test after each DEC. At most one step is active in any cycle, and done is set only when I is zero.
- R4: The datapath asserts completion in the cycle after an operation is evoked. `done_o` is therefore first seen high exactly 4N+4 rising edges after the edge that samples the start pulse.
- R5: A step stays in ST_FIRE for exactly one cycle. It leaves ST_WAIT only when completion is present.
- R6: Once set, `done_o` stays 1 and `sum_o` stays unchanged until the next accepted start. An accepted start clears `done_o` at the edge that samples it.
- R7: A start pulse that arrives while a computation is running is ignored. The running result and its timing are unchanged.
- R8: N is captured at the start edge. Later changes on `n_i` during the run do not affect the result.
- R9: S is 2·N_W bits wide, so an addition never wraps. Tested sums exceed 2^16, which shows the carry into the upper half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on a rising edge |
| n_i | input | N_W | Upper bound N, switch-style input |
| sum_o | output | 2*N_W | Accumulator S |
| done_o | output | 1 | High from the end of a run until the next accepted start |

## Verification
The bench measures the exact start-to-done latency for each N. A chain that skipped the completion wait, or that held a step for an extra cycle, would land on the wrong edge. N=1 checks that the zero test follows the first decrement; testing before the decrement would leave a result of 0 or run one pass too many. A start injected mid-run, and a change of `n_i` mid-run, would each corrupt the sum or the timing if the engine restarted or read N late. Sums above 2^16 and a long idle hold after done expose a narrow accumulator and a result that drifts.

// File: rtl/sumseq_pkg.sv
package sumseq_pkg;
    localparam int NSTEPS = 4;

    typedef enum logic [1:0] {
        STEP_CLR_S  = 2'd0,
        STEP_LOAD_I = 2'd1,
        STEP_ADD    = 2'd2,
        STEP_DEC    = 2'd3
    } step_id_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_WAIT = 2'd2
    } step_state_e;
endpackage

// File: rtl/sumseq_step.sv
module sumseq_step
    import sumseq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic activate_i,
    input  logic cmpl_i,
    output logic evoke_o,
    output logic next_o,
    output logic busy_o
);
    step_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (activate_i) state_d = ST_FIRE;
            ST_FIRE: state_d = ST_WAIT;
            ST_WAIT: if (cmpl_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        evoke_o = (state_q == ST_FIRE);
        next_o  = (state_q == ST_WAIT) && cmpl_i;
        busy_o  = (state_q != ST_IDLE);
    end

    // R5: one fire cycle, then wait
    assert_fire_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FIRE) |=> (state_q == ST_WAIT));
    // R5: no hand-off without completion
    assert_wait_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !cmpl_i) |=> (state_q == ST_WAIT));
endmodule

// File: rtl/sumseq_datapath.sv
module sumseq_datapath
    import sumseq_pkg::*;
#(
    parameter int N_W = 16,
    parameter int S_W = 2 * N_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n_i,
    input  logic [N_W-1:0]    n_i,
    input  logic [NSTEPS-1:0] evoke_i,
    output logic [S_W-1:0]    s_o,
    output logic              i_zero_o,
    output logic              cmpl_o
);
    localparam int CLR_B  = int'(STEP_CLR_S);
    localparam int LOAD_B = int'(STEP_LOAD_I);
    localparam int ADD_B  = int'(STEP_ADD);
    localparam int DEC_B  = int'(STEP_DEC);

    logic [N_W-1:0] n_q, i_q;
    logic [S_W-1:0] s_q;
    logic           cmpl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q    <= '0;
            i_q    <= '0;
            s_q    <= '0;
            cmpl_q <= 1'b0;
        end else begin
            if (load_n_i)        n_q <= n_i;
            if (evoke_i[CLR_B])  s_q <= '0;
            if (evoke_i[LOAD_B]) i_q <= n_q;
            if (evoke_i[ADD_B])  s_q <= s_q + S_W'(i_q);
            if (evoke_i[DEC_B])  i_q <= i_q - 1'b1;
            cmpl_q <= |evoke_i;
        end
    end

    assign s_o      = s_q;
    assign i_zero_o = (i_q == '0);
    assign cmpl_o   = cmpl_q;

    // R4: completion one cycle after any evoke
    assert_cmpl_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|evoke_i) |=> cmpl_o);
    // R9: accumulation never wraps
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        evoke_i[ADD_B] |=> (s_q >= $past(s_q)));
endmodule

// File: rtl/sum_chain_seq.sv
module sum_chain_seq
    import sumseq_pkg::*;
#(
    parameter int N_W = 16,
    localparam int S_W = 2 * N_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N_W-1:0] n_i,
    output logic [S_W-1:0] sum_o,
    output logic           done_o
);
    localparam int LOAD_B = int'(STEP_LOAD_I);
    localparam int ADD_B  = int'(STEP_ADD);
    localparam int DEC_B  = int'(STEP_DEC);

    logic [NSTEPS-1:0] act, evoke, nxt, busy;
    logic cmpl, i_zero, running, start_acc, finish, done_q;

    assign running   = |busy;
    assign start_acc = start_i && !running;
    assign finish    = nxt[DEC_B] && i_zero;

    always_comb begin
        act        = '0;
        act[0]     = start_acc;
        act[LOAD_B] = nxt[0];
        act[ADD_B]  = nxt[LOAD_B] | (nxt[DEC_B] & ~i_zero);
        act[DEC_B]  = nxt[ADD_B];
    end

    for (genvar k = 0; k < NSTEPS; k++) begin : g_step
        sumseq_step u_step (
            .clk        (clk),
            .rst_n      (rst_n),
            .activate_i (act[k]),
            .cmpl_i     (cmpl),
            .evoke_o    (evoke[k]),
            .next_o     (nxt[k]),
            .busy_o     (busy[k])
        );
    end

    sumseq_datapath #(.N_W(N_W), .S_W(S_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n_i (start_acc),
        .n_i      (n_i),
        .evoke_i  (evoke),
        .s_o      (sum_o),
        .i_zero_o (i_zero),
        .cmpl_o   (cmpl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         done_q <= 1'b0;
        else if (start_acc) done_q <= 1'b0;
        else if (finish)    done_q <= 1'b1;
    end

    assign done_o = done_q;

    // R3: single active step
    assert_one_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy));
    // R3: done only after I reached zero
    assert_done_on_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> i_zero);
    // R6: result and done held while idle
    assert_hold_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(sum_o)));
    // R7: start while running does not restart
    assert_ignore_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && start_i && !finish) |=> running);
endmodule

// File: tb/tb_sum_chain_seq.sv
`timescale 1ns/1ps
module tb_sum_chain_seq;
    localparam int N_W = 16;
    localparam int S_W = 2 * N_W;
    localparam int NV  = 10;
    localparam int LIMIT = 20000;

    localparam int unsigned VEC_N   [NV] = '{1, 2, 3, 5, 10, 100, 255, 256, 1000, 2000};
    localparam int unsigned VEC_SUM [NV] = '{1, 3, 6, 15, 55, 5050, 32640, 32896, 500500, 2001000};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [N_W-1:0] n_i = '0;
    logic [S_W-1:0] sum_o;
    logic done_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sum_chain_seq #(.N_W(N_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .n_i(n_i), .sum_o(sum_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start(input int unsigned n);
        @(negedge clk);
        n_i = N_W'(n);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // counts edges since the start edge; caller already advanced `cnt` edges
    task automatic wait_done(inout int cnt);
        while (!done_o && cnt < LIMIT) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 5.0);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int cnt;
        logic [S_W-1:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(done_o == 1'b0, "R1 done after reset", done_o, 0);
        check(sum_o == '0, "R1 sum after reset", sum_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o == 1'b0 && sum_o == '0, "R1 idle after release", sum_o, 0);

        // R2/R4/R9: vector table
        for (int v = 0; v < NV; v++) begin
            pulse_start(VEC_N[v]);
            cnt = 0;
            wait_done(cnt);
            check(sum_o == S_W'(VEC_SUM[v]), "R2 sum", sum_o, VEC_SUM[v]);
            check(cnt == 4 * VEC_N[v] + 4, "R4 latency", cnt, 4 * VEC_N[v] + 4);
            if (VEC_SUM[v] > 65535)
                check(sum_o[S_W-1:N_W] != '0, "R9 upper half", sum_o, VEC_SUM[v]);
        end

        // R6: hold after done, n_i changes while idle
        held = sum_o;
        n_i = 16'd9;
        repeat (25) @(negedge clk);
        check(done_o == 1'b1, "R6 done held", done_o, 1);
        check(sum_o == held, "R6 sum held", sum_o, held);

        // R6: accepted start clears done at the sampling edge
        pulse_start(4);
        check(done_o == 1'b0, "R6 done cleared", done_o, 0);
        cnt = 0;
        wait_done(cnt);
        check(sum_o == 10, "R6 restart sum", sum_o, 10);

        // R7: start during a run ignored
        pulse_start(50);
        cnt = 0;
        repeat (9) begin @(posedge clk); cnt++; @(negedge clk); end
        n_i = 16'd7;
        start_i = 1'b1;
        @(posedge clk); cnt++; @(negedge clk);
        start_i = 1'b0;
        repeat (40) begin @(posedge clk); cnt++; @(negedge clk); end
        n_i = 16'd3;
        start_i = 1'b1;
        @(posedge clk); cnt++; @(negedge clk);
        start_i = 1'b0;
        wait_done(cnt);
        check(sum_o == 1275, "R7 sum unaffected", sum_o, 1275);
        check(cnt == 204, "R7 latency unaffected", cnt, 204);

        // R8: n_i change after start edge ignored
        pulse_start(20);
        n_i = 16'd3;
        cnt = 0;
        wait_done(cnt);
        check(sum_o == 210, "R8 captured N", sum_o, 210);
        check(cnt == 84, "R8 latency", cnt, 84);

        // R3: single-pass boundary N=1 after a long run
        pulse_start(1);
        cnt = 0;
        wait_done(cnt);
        check(sum_o == 1 && cnt == 8, "R3 N=1 order", sum_o, 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule